// File: doc/BRIEF.md
# Memory Instruction Class Decoder

This block sorts the memory-format instructions of a 64-bit RISC pipeline into classes. For each instruction it reports what kind of access it is (plain load, plain store, atomic byte set, register/memory swap, no-op, or fault) and how wide the access is, as an 8, 16, 32 or 64-bit code. It also raises flags for sign extension, even/odd register pairs, alternate address space, floating-point destination and FP status register transfer. In the same pass it adds up the effective address from the two source operands or from a sign-extended 13-bit immediate.

The issue stage presents the opcode field, the X bit, the immediate-select bit, both source register values and the immediate, together with a valid strobe. One clock later a registered bundle appears with a matching valid. Downstream stages use this bundle to drive the memory port, the writeback muxes and the trap logic. Opcodes that are not listed raise an illegal-instruction flag. Quad-precision FP accesses come out as a fault class without that flag, and the trap logic reads this as "FP unit disabled".

Top module: `lsdec_unit`

## Requirements
- R1: While reset is held and just after it, out_valid, illegal and eff_addr are all zero.
- R2: out_valid equals in_valid delayed by one clock. When in_valid is low, all other outputs keep their previous values.
- R3: Integer loads. op3 0x00/0x01/0x02/0x03 are zero-extending loads of 32/8/16/64 bits. op3 0x08/0x09/0x0A are sign-extending loads of 32/8/16 bits. op3 0x0B is a 64-bit load with sign_ext low. Class codes are LOAD=0, STORE=1, ATOMIC=2, SWAP=3, NOP=4, FAULT=5. Size codes are 0=8, 1=16, 2=32, 3=64 bits.
- R4: Integer stores. op3 0x04/0x05/0x06/0x07 are STORE of 32/8/16/64 bits, and op3 0x0E is a 64-bit STORE.
- R5: reg_pair is high only for the pair forms 0x03, 0x07, 0x13 and 0x17. Its size is always 64. The low word goes to the even register and the high word to the odd one.
- R6: op3 0x0D gives class ATOMIC with size 8 (return old byte, write 0xFF). op3 0x0F gives class SWAP with size 32.
- R7: op3 0x10–0x1F decode the same as op3 minus 0x10, with alt_space high. The FP forms 0x30, 0x33, 0x34 and 0x37 also set alt_space.
- R8: With imm_mode low, eff_addr is rs1_val + rs2_val modulo 2^64.
- R9: With imm_mode high, eff_addr is rs1_val plus simm13 sign-extended from bit 12.
- R10: op3 0x21 (load) and 0x25 (store) set fsr_xfer. x_bit=0 gives size 32 and x_bit=1 gives size 64. fsr_keep_hi is high only for 0x21 with x_bit=0, which keeps status bits 63:32. x_bit has no effect on any other opcode.
- R11: op3 0x22, 0x26, 0x32 and 0x36 give class FAULT with illegal low.
- R12: op3 0x2D gives class NOP with illegal low.
- R13: Every other op3 (0x0C, 0x1C, 0x28–0x2C, 0x2E, 0x2F, 0x31, 0x35, 0x38–0x3F) gives class FAULT with illegal high.
- R14: FP data forms set fp_reg. 0x20 is a 32-bit LOAD, 0x23 a 64-bit LOAD, 0x24 a 32-bit STORE and 0x27 a 64-bit STORE, and likewise for their alternate-space forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| op3 | input | 6 | Memory opcode field |
| x_bit | input | 1 | Extended-width select for status transfers |
| imm_mode | input | 1 | 1 = immediate addressing, 0 = register+register |
| rs1_val | input | 64 | First source operand |
| rs2_val | input | 64 | Second source operand |
| simm13 | input | 13 | Signed immediate |
| out_valid | output | 1 | Registered result valid |
| op_class | output | 3 | Operation class code |
| acc_size | output | 2 | Access width code |
| sign_ext | output | 1 | Load result is sign-extended |
| reg_pair | output | 1 | Access spans an even/odd register pair |
| alt_space | output | 1 | Alternate address space form |
| fp_reg | output | 1 | Data register is in the FP file |
| fsr_xfer | output | 1 | Transfer targets the FP status register |
| fsr_keep_hi | output | 1 | Status load keeps upper 32 bits |
| illegal | output | 1 | Unlisted opcode |
| eff_addr | output | 64 | Effective address |

## Verification
The bench steps through every listed opcode, including its alternate-space copy, and samples unlisted ones from each hole in the map. A decoder that forgot the 0x0C gap, or let alternate space leak into the FP faults, would give the wrong class or flag there. Quad FP and unlisted opcodes are checked against each other, so a design that merged the two faults would show the wrong illegal bit. The immediate cases use -1, -4096 and +4095. A decoder that zero-extended the immediate would give an address off by 2^13 or more. The status transfers are run with both X values, and X is also toggled on an ordinary store to prove it is ignored there. Dropping in_valid must freeze the previous result; a design that let outputs update on it would show the change.

// File: rtl/lsdec_pkg.sv
package lsdec_pkg;

    typedef enum logic [2:0] {
        CLS_LOAD   = 3'd0,
        CLS_STORE  = 3'd1,
        CLS_ATOMIC = 3'd2,
        CLS_SWAP   = 3'd3,
        CLS_NOP    = 3'd4,
        CLS_FAULT  = 3'd5
    } op_class_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } acc_size_e;

    typedef struct packed {
        op_class_e cls;
        acc_size_e size;
        logic      sext;
        logic      pair;
        logic      alt;
        logic      fpr;
        logic      fsr;
        logic      keep_hi;
        logic      illegal;
    } dec_t;

    localparam int OP3_W = 6;

endpackage

// File: rtl/lsdec_class.sv
module lsdec_class
    import lsdec_pkg::*;
(
    input  logic [OP3_W-1:0] op3,
    input  logic             x_bit,
    output dec_t             dec
);

    // Integer half of the map: bit 4 picks alternate space, low nibble the op.
    dec_t int_d;
    always_comb begin
        int_d         = '0;
        int_d.cls     = CLS_LOAD;
        int_d.alt     = op3[4];
        unique case (op3[3:0])
            4'h0: int_d.size = SZ_32;
            4'h1: int_d.size = SZ_8;
            4'h2: int_d.size = SZ_16;
            4'h3: begin int_d.size = SZ_64; int_d.pair = 1'b1; end
            4'h4: begin int_d.cls = CLS_STORE; int_d.size = SZ_32; end
            4'h5: begin int_d.cls = CLS_STORE; int_d.size = SZ_8;  end
            4'h6: begin int_d.cls = CLS_STORE; int_d.size = SZ_16; end
            4'h7: begin
                int_d.cls  = CLS_STORE;
                int_d.size = SZ_64;
                int_d.pair = 1'b1;
            end
            4'h8: begin int_d.size = SZ_32; int_d.sext = 1'b1; end
            4'h9: begin int_d.size = SZ_8;  int_d.sext = 1'b1; end
            4'hA: begin int_d.size = SZ_16; int_d.sext = 1'b1; end
            4'hB: int_d.size = SZ_64;
            4'hC: begin
                int_d.cls     = CLS_FAULT;
                int_d.alt     = 1'b0;
                int_d.illegal = 1'b1;
            end
            4'hD: begin int_d.cls = CLS_ATOMIC; int_d.size = SZ_8;  end
            4'hE: begin int_d.cls = CLS_STORE;  int_d.size = SZ_64; end
            4'hF: begin int_d.cls = CLS_SWAP;   int_d.size = SZ_32; end
            default: ;
        endcase
    end

    // Floating-point half of the map.
    dec_t fp_d;
    always_comb begin
        fp_d         = '0;
        fp_d.cls     = CLS_FAULT;
        fp_d.illegal = 1'b1;
        unique case (op3[4:0])
            5'h00, 5'h10: begin
                fp_d.cls = CLS_LOAD;  fp_d.size = SZ_32;
                fp_d.fpr = 1'b1;      fp_d.illegal = 1'b0;
                fp_d.alt = op3[4];
            end
            5'h03, 5'h13: begin
                fp_d.cls = CLS_LOAD;  fp_d.size = SZ_64;
                fp_d.fpr = 1'b1;      fp_d.illegal = 1'b0;
                fp_d.alt = op3[4];
            end
            5'h04, 5'h14: begin
                fp_d.cls = CLS_STORE; fp_d.size = SZ_32;
                fp_d.fpr = 1'b1;      fp_d.illegal = 1'b0;
                fp_d.alt = op3[4];
            end
            5'h07, 5'h17: begin
                fp_d.cls = CLS_STORE; fp_d.size = SZ_64;
                fp_d.fpr = 1'b1;      fp_d.illegal = 1'b0;
                fp_d.alt = op3[4];
            end
            5'h01: begin
                fp_d.cls     = CLS_LOAD;
                fp_d.size    = x_bit ? SZ_64 : SZ_32;
                fp_d.fsr     = 1'b1;
                fp_d.keep_hi = ~x_bit;
                fp_d.illegal = 1'b0;
            end
            5'h05: begin
                fp_d.cls     = CLS_STORE;
                fp_d.size    = x_bit ? SZ_64 : SZ_32;
                fp_d.fsr     = 1'b1;
                fp_d.illegal = 1'b0;
            end
            5'h02, 5'h06, 5'h12, 5'h16: fp_d.illegal = 1'b0;
            5'h0D: begin
                fp_d.cls     = CLS_NOP;
                fp_d.illegal = 1'b0;
            end
            default: ;
        endcase
    end

    assign dec = op3[5] ? fp_d : int_d;

endmodule

// File: rtl/lsdec_agen.sv
module lsdec_agen #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 13
) (
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  rs2_val,
    input  logic [IMM_W-1:0] simm,
    input  logic             imm_mode,
    output logic [XLEN-1:0]  ea
);

    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_ext = {{EXT_W{simm[IMM_W-1]}}, simm};
        end else begin : g_trunc
            assign imm_ext = simm[XLEN-1:0];
        end
    endgenerate

    logic [XLEN-1:0] addend;
    assign addend = imm_mode ? imm_ext : rs2_val;
    assign ea     = rs1_val + addend;

endmodule

// File: rtl/lsdec_unit.sv
module lsdec_unit
    import lsdec_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [5:0]       op3,
    input  logic             x_bit,
    input  logic             imm_mode,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  rs2_val,
    input  logic [IMM_W-1:0] simm13,
    output logic             out_valid,
    output logic [2:0]       op_class,
    output logic [1:0]       acc_size,
    output logic             sign_ext,
    output logic             reg_pair,
    output logic             alt_space,
    output logic             fp_reg,
    output logic             fsr_xfer,
    output logic             fsr_keep_hi,
    output logic             illegal,
    output logic [XLEN-1:0]  eff_addr
);

    typedef struct packed {
        logic            valid;
        dec_t            dec;
        logic [XLEN-1:0] ea;
    } stage_t;

    dec_t            dec_w;
    logic [XLEN-1:0] ea_w;

    lsdec_class u_class (
        .op3   (op3),
        .x_bit (x_bit),
        .dec   (dec_w)
    );

    lsdec_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agen (
        .rs1_val  (rs1_val),
        .rs2_val  (rs2_val),
        .simm     (simm13),
        .imm_mode (imm_mode),
        .ea       (ea_w)
    );

    stage_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.dec = dec_w;
            st_d.ea  = ea_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign op_class    = st_q.dec.cls;
    assign acc_size    = st_q.dec.size;
    assign sign_ext    = st_q.dec.sext;
    assign reg_pair    = st_q.dec.pair;
    assign alt_space   = st_q.dec.alt;
    assign fp_reg      = st_q.dec.fpr;
    assign fsr_xfer    = st_q.dec.fsr;
    assign fsr_keep_hi = st_q.dec.keep_hi;
    assign illegal     = st_q.dec.illegal;
    assign eff_addr    = st_q.ea;

endmodule

// File: rtl/lsdec_unit_chk.sv
module lsdec_unit_chk #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [5:0]       op3,
    input logic             x_bit,
    input logic             imm_mode,
    input logic [XLEN-1:0]  rs1_val,
    input logic [XLEN-1:0]  rs2_val,
    input logic [IMM_W-1:0] simm13,
    input logic             out_valid,
    input logic [2:0]       op_class,
    input logic [1:0]       acc_size,
    input logic             sign_ext,
    input logic             reg_pair,
    input logic             alt_space,
    input logic             fp_reg,
    input logic             fsr_xfer,
    input logic             fsr_keep_hi,
    input logic             illegal,
    input logic [XLEN-1:0]  eff_addr
);

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(eff_addr) && $stable(op_class)
                       && $stable(acc_size)));

    p_sext_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sign_ext) |-> (op_class == 3'd0));

    p_pair_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && reg_pair) |-> (acc_size == 2'd3 && !fp_reg));

    p_alt_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op3[5:4] == 2'b01 && op3[3:0] != 4'hC)
            |=> (alt_space && !illegal));

    p_ea_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !imm_mode) |=> (eff_addr == $past(rs1_val + rs2_val)));

    p_keep_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fsr_keep_hi) |-> (fsr_xfer && acc_size == 2'd2
                                        && op_class == 3'd0));

    p_illegal_fault_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> (op_class == 3'd5 && !alt_space));

    p_unused_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op3[5:3] == 3'b111) |=> illegal);

endmodule

bind lsdec_unit lsdec_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/lsdec_unit_bench.sv
`timescale 1ns/1ps
module lsdec_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  op3 = '0;
    logic        x_bit = 1'b0;
    logic        imm_mode = 1'b0;
    logic [63:0] rs1_val = '0;
    logic [63:0] rs2_val = '0;
    logic [12:0] simm13 = '0;
    logic        out_valid;
    logic [2:0]  op_class;
    logic [1:0]  acc_size;
    logic        sign_ext, reg_pair, alt_space, fp_reg;
    logic        fsr_xfer, fsr_keep_hi, illegal;
    logic [63:0] eff_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lsdec_unit u_lsdec_unit (
        .clk, .rst_n, .in_valid, .op3, .x_bit, .imm_mode,
        .rs1_val, .rs2_val, .simm13, .out_valid, .op_class, .acc_size,
        .sign_ext, .reg_pair, .alt_space, .fp_reg, .fsr_xfer,
        .fsr_keep_hi, .illegal, .eff_addr
    );

    // Vector: op3, x, class, size, {sext,pair,alt,fpr,fsr,keep,ill}
    localparam int NV = 43;
    localparam logic [18:0] VEC [NV] = '{
        {6'h00,1'b0,3'd0,2'd2,7'b0000000}, // R3
        {6'h01,1'b0,3'd0,2'd0,7'b0000000}, // R3
        {6'h02,1'b0,3'd0,2'd1,7'b0000000}, // R3
        {6'h03,1'b0,3'd0,2'd3,7'b0100000}, // R3 R5
        {6'h04,1'b0,3'd1,2'd2,7'b0000000}, // R4
        {6'h05,1'b0,3'd1,2'd0,7'b0000000}, // R4
        {6'h06,1'b0,3'd1,2'd1,7'b0000000}, // R4
        {6'h07,1'b0,3'd1,2'd3,7'b0100000}, // R4 R5
        {6'h08,1'b0,3'd0,2'd2,7'b1000000}, // R3
        {6'h09,1'b0,3'd0,2'd0,7'b1000000}, // R3
        {6'h0A,1'b0,3'd0,2'd1,7'b1000000}, // R3
        {6'h0B,1'b0,3'd0,2'd3,7'b0000000}, // R3
        {6'h0C,1'b0,3'd5,2'd0,7'b0000001}, // R13
        {6'h0D,1'b0,3'd2,2'd0,7'b0000000}, // R6
        {6'h0E,1'b0,3'd1,2'd3,7'b0000000}, // R4
        {6'h0F,1'b0,3'd3,2'd2,7'b0000000}, // R6
        {6'h11,1'b0,3'd0,2'd0,7'b0010000}, // R7
        {6'h13,1'b0,3'd0,2'd3,7'b0110000}, // R7 R5
        {6'h16,1'b0,3'd1,2'd1,7'b0010000}, // R7
        {6'h19,1'b0,3'd0,2'd0,7'b1010000}, // R7
        {6'h1D,1'b0,3'd2,2'd0,7'b0010000}, // R7
        {6'h1F,1'b0,3'd3,2'd2,7'b0010000}, // R7
        {6'h1C,1'b0,3'd5,2'd0,7'b0000001}, // R13
        {6'h20,1'b0,3'd0,2'd2,7'b0001000}, // R14
        {6'h21,1'b0,3'd0,2'd2,7'b0000110}, // R10
        {6'h21,1'b1,3'd0,2'd3,7'b0000100}, // R10
        {6'h22,1'b0,3'd5,2'd0,7'b0000000}, // R11
        {6'h23,1'b0,3'd0,2'd3,7'b0001000}, // R14
        {6'h24,1'b0,3'd1,2'd2,7'b0001000}, // R14
        {6'h25,1'b0,3'd1,2'd2,7'b0000100}, // R10
        {6'h25,1'b1,3'd1,2'd3,7'b0000100}, // R10
        {6'h26,1'b0,3'd5,2'd0,7'b0000000}, // R11
        {6'h27,1'b0,3'd1,2'd3,7'b0001000}, // R14
        {6'h2D,1'b0,3'd4,2'd0,7'b0000000}, // R12
        {6'h30,1'b0,3'd0,2'd2,7'b0011000}, // R7 R14
        {6'h32,1'b0,3'd5,2'd0,7'b0000000}, // R11
        {6'h33,1'b0,3'd0,2'd3,7'b0011000}, // R7 R14
        {6'h34,1'b0,3'd1,2'd2,7'b0011000}, // R7 R14
        {6'h36,1'b0,3'd5,2'd0,7'b0000000}, // R11
        {6'h37,1'b0,3'd1,2'd3,7'b0011000}, // R7 R14
        {6'h3C,1'b0,3'd5,2'd0,7'b0000001}, // R13
        {6'h28,1'b0,3'd5,2'd0,7'b0000001}, // R13
        {6'h05,1'b1,3'd1,2'd0,7'b0000000}  // R10: x ignored
    };

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] sx13(input logic [12:0] v);
        return {{51{v[12]}}, v};
    endfunction

    task automatic drive(input logic [5:0] o, input logic x, input logic im,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [12:0] s);
        op3 = o; x_bit = x; imm_mode = im;
        rs1_val = a; rs2_val = b; simm13 = s; in_valid = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 illegal", 64'(illegal), 64'd0);
        chk("R1 eff_addr", eff_addr, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after release", 64'(out_valid), 64'd0);

        // Table walk, back-to-back strobes
        for (int i = 0; i < NV; i++) begin
            logic [63:0] a, b, exp_ea;
            logic [12:0] s;
            logic        im;
            a  = 64'h1000_0000_0000_0000 + 64'(i) * 64'h1111;
            b  = 64'(i) * 64'h35;
            s  = (i % 3 == 0) ? 13'(13'h1FFF - i * 150) : 13'(i * 97);
            im = i[0];
            exp_ea = im ? a + sx13(s) : a + b;
            drive(VEC[i][18:13], VEC[i][12], im, a, b, s);
            @(negedge clk);
            chk("R2 out_valid", 64'(out_valid), 64'd1);
            chk($sformatf("R3/R4/R6/R11/R12/R13 class op3=%h", VEC[i][18:13]),
                64'(op_class), 64'(VEC[i][11:9]));
            chk($sformatf("R3/R4/R10/R14 size op3=%h", VEC[i][18:13]),
                64'(acc_size), 64'(VEC[i][8:7]));
            chk($sformatf("R3/R5/R7/R10/R13/R14 flags op3=%h", VEC[i][18:13]),
                64'({sign_ext, reg_pair, alt_space, fp_reg, fsr_xfer,
                     fsr_keep_hi, illegal}), 64'(VEC[i][6:0]));
            chk(im ? "R9 ea imm" : "R8 ea reg", eff_addr, exp_ea);
        end

        // R2: hold when strobe drops, inputs changed underneath
        drive(6'h0F, 1'b0, 1'b0, 64'hAAAA, 64'h5555, 13'd0);
        @(negedge clk);
        in_valid = 1'b0; op3 = 6'h3F; rs1_val = 64'h1; rs2_val = 64'h2;
        @(negedge clk);
        chk("R2 valid low", 64'(out_valid), 64'd0);
        chk("R2 hold class", 64'(op_class), 64'd3);
        chk("R2 hold ea", eff_addr, 64'hFFFF);
        chk("R2 hold illegal", 64'(illegal), 64'd0);

        // R9: immediate extremes
        drive(6'h00, 1'b0, 1'b1, 64'h100, 64'hDEAD, 13'h1FFF);
        @(negedge clk);
        chk("R9 imm -1", eff_addr, 64'hFF);
        drive(6'h00, 1'b0, 1'b1, 64'h0, 64'h0, 13'h1000);
        @(negedge clk);
        chk("R9 imm -4096", eff_addr, 64'hFFFF_FFFF_FFFF_F000);
        drive(6'h00, 1'b0, 1'b1, 64'h1, 64'h0, 13'h0FFF);
        @(negedge clk);
        chk("R9 imm +4095", eff_addr, 64'h1000);

        // R8: wraparound
        drive(6'h04, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 13'h1FFF);
        @(negedge clk);
        chk("R8 wrap", eff_addr, 64'h1);

        // R13: sweep the upper unused region
        for (int k = 6'h38; k <= 6'h3F; k++) begin
            drive(6'(k), 1'b0, 1'b0, 64'h0, 64'h0, 13'h0);
            @(negedge clk);
            chk($sformatf("R13 illegal op3=%h", k), 64'(illegal), 64'd1);
        end
        in_valid = 1'b0;

        // R1: reset again clears a held result
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears illegal", 64'(illegal), 64'd0);
        chk("R1 reset clears ea", eff_addr, 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule